// File: doc/BRIEF.md
# Balanced Ternary Vector ALU

This block performs one signed-digit, base-3 operation per accepted request on words of N trits. Every trit travels as a 2-bit code. Each request carries an opcode, three trit-word operands (`a`, `b`, `c`), one control trit (`pick`), a shift distance, and a signed binary sample with two thresholds. On the clock edge where `in_valid` is high, the block computes and registers a result word, a carry trit and an illegal-code flag. `out_valid` then stays high for the following cycle.

The operations are:
- add and subtract, with normalization of each digit into {−1, 0, +1};
- absolute value;
- three-way compare;
- shift by powers of three, left or right;
- three-way select;
- a two-threshold quantizer that converts the binary sample into one trit.

A two-state machine holds the valid status:
- **ST_IDLE**: no result is presented. The machine goes to ST_HOLD on *accept* (`in_valid` high). Otherwise it stays in ST_IDLE.
- **ST_HOLD**: a fresh result is presented. The machine stays in ST_HOLD on *chain* (`in_valid` high again). It returns to ST_IDLE on *drain* (`in_valid` low).

Top module: `bt_vec_alu`

## Requirements
- R1: Trit codes are 00 = 0, 01 = +1, 10 = −1 and 11 = illegal. Trit i of a word sits in bits [2i+1:2i] and has weight 3^i. The result word and the carry never contain code 11, and every input 11 code is used as 0.
- R2: A request sampled with `in_valid` high at a rising edge appears on `result`, `carry` and `err` right after that edge, with `out_valid` high for that one cycle. With no request, `out_valid` falls and `result`, `carry` and `err` hold.
- R3: While `rst_n` is low, `out_valid` and `err` are 0 and `result` and `carry` are all-zero codes.
- R4: Opcode 000 (add) produces a+b wrapped into the N-trit balanced range. The overflow is given as the carry trit, so result + carry·3^N = a+b.
- R5: Opcode 001 (subtract) produces a−b in the same way as R4. Every trit of b is negated before the add.
- R6: Opcode 010 produces |a|. The word is negated when its most significant nonzero trit is −1, and the carry is 0.
- R7: Opcode 011 places the sign of a−b in trit 0 of the result, as −1, 0 or +1. All higher trits are 0.
- R8: Opcode 100 multiplies a by 3^k, with k = `shamt`. Trits pushed above position N−1 are lost, and zeros fill the low positions. When k ≥ N the result is 0.
- R9: Opcode 101 drops the k low trits of a, with k = `shamt`. This gives a/3^k rounded to the nearest integer. When k ≥ N the result is 0.
- R10: Opcode 110 outputs a when `pick` = −1, b when `pick` = 0, and c when `pick` = +1. An illegal `pick` acts as 0.
- R11: Opcode 111 puts a trit in position 0 of the result: −1 if `sample` < `thr_lo`, +1 if `sample` > `thr_hi`, and 0 otherwise. The comparisons are signed, and all higher trits are 0.
- R12: `err` is set with the result whenever any trit of a, b or c, or `pick`, carries code 11.
- R13: The carry is 0 for every opcode other than add and subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Opcode |
| a | input | 2N | First trit-word operand |
| b | input | 2N | Second trit-word operand |
| c | input | 2N | Third operand, used by select |
| pick | input | 2 | Control trit for select |
| shamt | input | clog2(N+1) | Shift distance k in trits |
| sample | input | W | Signed value for the quantizer |
| thr_lo | input | W | Signed lower threshold |
| thr_hi | input | W | Signed upper threshold |
| out_valid | output | 1 | Result presented this cycle |
| result | output | 2N | Registered result word |
| carry | output | 2 | Registered carry trit |
| err | output | 1 | Registered illegal-code flag |

## Verification
The bench drives the largest positive and negative words into add and subtract. An adder with a wrong normalization or a dropped top carry would return a wrong word or a zero carry there. It applies right shifts to values whose dropped trits round up, and shifts of exactly N. A shifter that floors, or that wraps its index, would give the wrong quotient or leak operand trits. It also checks:
- quantizer samples that sit exactly on a threshold, which a strict and non-strict comparison mix-up would push to ±1;
- words and select controls that hold code 11, where a design that decodes 11 as a value, or misses it in the flag, would give a wrong result or no flag.

// File: rtl/bt_pkg.sv
package bt_pkg;
    typedef logic [1:0] trit_t;

    localparam trit_t T_ZERO = 2'b00;
    localparam trit_t T_POS  = 2'b01;
    localparam trit_t T_NEG  = 2'b10;
    localparam trit_t T_BAD  = 2'b11;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_ABS = 3'd2,
        OP_CMP = 3'd3,
        OP_SHL = 3'd4,
        OP_SHR = 3'd5,
        OP_SEL = 3'd6,
        OP_SGN = 3'd7
    } alu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } alu_state_e;

    function automatic logic signed [2:0] t_val(trit_t t);
        case (t)
            T_POS:   return 3'sd1;
            T_NEG:   return -3'sd1;
            default: return 3'sd0;
        endcase
    endfunction

    function automatic trit_t t_enc(logic signed [2:0] v);
        if (v > 3'sd0) return T_POS;
        if (v < 3'sd0) return T_NEG;
        return T_ZERO;
    endfunction

    // legal codes only: swaps +1 and -1, keeps 0
    function automatic trit_t t_flip(trit_t t);
        return {t[0], t[1]};
    endfunction
endpackage

// File: rtl/bt_adder.sv
module bt_adder
    import bt_pkg::*;
#(
    parameter int N = 8,
    localparam int WB = 2 * N
) (
    input  logic [WB-1:0] x,
    input  logic [WB-1:0] y,
    output logic [WB-1:0] s,
    output trit_t         cout
);
    logic signed [3:0] acc;
    logic signed [2:0] cy;

    always_comb begin
        cy  = 3'sd0;
        acc = 4'sd0;
        s   = '0;
        for (int i = 0; i < N; i++) begin
            acc = 4'(t_val(x[2*i +: 2])) + 4'(t_val(y[2*i +: 2])) + 4'(cy);
            if (acc > 4'sd1) begin
                acc = acc - 4'sd3;
                cy  = 3'sd1;
            end else if (acc < -4'sd1) begin
                acc = acc + 4'sd3;
                cy  = -3'sd1;
            end else begin
                cy  = 3'sd0;
            end
            s[2*i +: 2] = t_enc(acc[2:0]);
        end
        cout = t_enc(cy);
    end
endmodule

// File: rtl/bt_shifter.sv
module bt_shifter
    import bt_pkg::*;
#(
    parameter int N = 8,
    parameter int SHW = 4,
    localparam int WB = 2 * N
) (
    input  logic [WB-1:0]  w,
    input  logic [SHW-1:0] amt,
    input  logic           left,
    output logic [WB-1:0]  o
);
    int src;

    always_comb begin
        o   = '0;
        src = 0;
        for (int i = 0; i < N; i++) begin
            src = left ? i - int'(amt) : i + int'(amt);
            for (int j = 0; j < N; j++) begin
                if (j == src) o[2*i +: 2] = w[2*j +: 2];
            end
        end
    end
endmodule

// File: rtl/bt_quant.sv
module bt_quant
    import bt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic signed [W-1:0] sample,
    input  logic signed [W-1:0] lo,
    input  logic signed [W-1:0] hi,
    output trit_t               q
);
    always_comb begin
        if (sample < lo)      q = T_NEG;
        else if (sample > hi) q = T_POS;
        else                  q = T_ZERO;
    end
endmodule

// File: rtl/bt_vec_alu.sv
module bt_vec_alu
    import bt_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 16,
    localparam int SHW = $clog2(N + 1),
    localparam int WB = 2 * N
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          op,
    input  logic [WB-1:0]       a,
    input  logic [WB-1:0]       b,
    input  logic [WB-1:0]       c,
    input  logic [1:0]          pick,
    input  logic [SHW-1:0]      shamt,
    input  logic signed [W-1:0] sample,
    input  logic signed [W-1:0] thr_lo,
    input  logic signed [W-1:0] thr_hi,
    output logic                out_valid,
    output logic [WB-1:0]       result,
    output logic [1:0]          carry,
    output logic                err
);
    alu_op_e    op_e;
    alu_state_e state, nxt_state;

    logic [WB-1:0] ca, cb, cc, na, nb;
    logic [N-1:0]  bad_a, bad_b, bad_c, rbad;
    logic          pick_bad, in_bad;
    trit_t         pick_c;

    assign op_e = alu_op_e'(op);

    // input cleaning: code 11 is used as 0 and flagged
    for (genvar g = 0; g < N; g++) begin : g_clean
        assign bad_a[g] = &a[2*g +: 2];
        assign bad_b[g] = &b[2*g +: 2];
        assign bad_c[g] = &c[2*g +: 2];
        assign ca[2*g +: 2] = bad_a[g] ? T_ZERO : a[2*g +: 2];
        assign cb[2*g +: 2] = bad_b[g] ? T_ZERO : b[2*g +: 2];
        assign cc[2*g +: 2] = bad_c[g] ? T_ZERO : c[2*g +: 2];
        assign na[2*g +: 2] = t_flip(ca[2*g +: 2]);
        assign nb[2*g +: 2] = t_flip(cb[2*g +: 2]);
        assign rbad[g]      = &result[2*g +: 2];
    end

    assign pick_bad = &pick;
    assign pick_c   = pick_bad ? T_ZERO : pick;
    assign in_bad   = (|bad_a) | (|bad_b) | (|bad_c) | pick_bad;

    // datapath units
    logic [WB-1:0] addend, sum_w, shf_w;
    trit_t         sum_c, q_t;

    assign addend = (op_e == OP_SUB) ? nb : cb;

    bt_adder #(.N(N)) u_add (
        .x(ca), .y(addend), .s(sum_w), .cout(sum_c)
    );

    bt_shifter #(.N(N), .SHW(SHW)) u_shf (
        .w(ca), .amt(shamt), .left(op_e == OP_SHL), .o(shf_w)
    );

    bt_quant #(.W(W)) u_qnt (
        .sample(sample), .lo(thr_lo), .hi(thr_hi), .q(q_t)
    );

    // absolute value: leading nonzero trit decides
    trit_t         lead_t;
    logic [WB-1:0] abs_w;
    always_comb begin
        lead_t = T_ZERO;
        for (int i = 0; i < N; i++) begin
            if (ca[2*i +: 2] != T_ZERO) lead_t = ca[2*i +: 2];
        end
    end
    assign abs_w = (lead_t == T_NEG) ? na : ca;

    // compare: first differing trit from the top decides
    trit_t cmp_t;
    always_comb begin
        cmp_t = T_ZERO;
        for (int i = N - 1; i >= 0; i--) begin
            if (cmp_t == T_ZERO && ca[2*i +: 2] != cb[2*i +: 2]) begin
                cmp_t = (t_val(ca[2*i +: 2]) > t_val(cb[2*i +: 2])) ? T_POS : T_NEG;
            end
        end
    end

    // select
    logic [WB-1:0] sel_w;
    always_comb begin
        unique case (pick_c)
            T_NEG:   sel_w = ca;
            T_POS:   sel_w = cc;
            default: sel_w = cb;
        endcase
    end

    // result mux
    logic [WB-1:0] nxt_w;
    trit_t         nxt_c;
    always_comb begin
        nxt_c = T_ZERO;
        unique case (op_e)
            OP_ADD, OP_SUB: begin
                nxt_w = sum_w;
                nxt_c = sum_c;
            end
            OP_ABS:         nxt_w = abs_w;
            OP_CMP:         nxt_w = {{(WB-2){1'b0}}, cmp_t};
            OP_SHL, OP_SHR: nxt_w = shf_w;
            OP_SEL:         nxt_w = sel_w;
            OP_SGN:         nxt_w = {{(WB-2){1'b0}}, q_t};
            default:        nxt_w = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // next state: accept / chain / drain
    always_comb begin
        unique case (state)
            ST_IDLE: nxt_state = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: nxt_state = in_valid ? ST_HOLD : ST_IDLE;
            default: nxt_state = ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            carry  <= T_ZERO;
            err    <= 1'b0;
        end else if (in_valid) begin
            result <= nxt_w;
            carry  <= nxt_c;
            err    <= in_bad;
        end
    end

    assign out_valid = (state == ST_HOLD);

    // R1
    legal_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rbad == '0 && carry != T_BAD));

    // R2
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(result) && $stable(carry) && !out_valid));

    // R12
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (err == $past(in_bad)));

    // R13
    carry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_e) != OP_ADD && $past(op_e) != OP_SUB) |-> carry == T_ZERO);

    // R7
    cmp_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_e) == OP_CMP) |-> result[WB-1:2] == '0);
endmodule

// File: tb/test_bt_vec_alu.sv
`timescale 1ns/1ps
module test_bt_vec_alu;
    localparam int N = 8;
    localparam int W = 16;
    localparam int WB = 2 * N;
    localparam int SHW = 4;
    localparam longint P = 6561;
    localparam longint HALF = 3280;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] op = '0;
    logic [WB-1:0] a = '0, b = '0, c = '0;
    logic [1:0] pick = '0;
    logic [SHW-1:0] shamt = '0;
    logic signed [W-1:0] sample = '0, thr_lo = '0, thr_hi = '0;
    logic out_valid;
    logic [WB-1:0] result;
    logic [1:0] carry;
    logic err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bt_vec_alu #(.N(N), .W(W)) i_bt_vec_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .a(a), .b(b), .c(c), .pick(pick), .shamt(shamt),
        .sample(sample), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .out_valid(out_valid), .result(result), .carry(carry), .err(err)
    );

    function automatic int dec(logic [WB-1:0] w);
        int v = 0;
        int p = 1;
        for (int i = 0; i < N; i++) begin
            if (w[2*i +: 2] == 2'b01) v += p;
            else if (w[2*i +: 2] == 2'b10) v -= p;
            p *= 3;
        end
        return v;
    endfunction

    function automatic logic [WB-1:0] enc(longint v);
        logic [WB-1:0] w = '0;
        for (int i = 0; i < N; i++) begin
            longint r = ((v % 3) + 3) % 3;
            if (r == 0) begin w[2*i +: 2] = 2'b00; v = v / 3; end
            else if (r == 1) begin w[2*i +: 2] = 2'b01; v = (v - 1) / 3; end
            else begin w[2*i +: 2] = 2'b10; v = (v + 1) / 3; end
        end
        return w;
    endfunction

    function automatic logic [1:0] enc1(longint v);
        return (v > 0) ? 2'b01 : (v < 0) ? 2'b10 : 2'b00;
    endfunction

    function automatic logic [WB-1:0] rnd_word();
        logic [WB-1:0] w;
        for (int i = 0; i < N; i++) begin
            int r = int'($urandom % 3);
            w[2*i +: 2] = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b10;
        end
        return w;
    endfunction

    function automatic string tag_of(logic [2:0] o);
        case (o)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic longint pow3(int k);
        longint p = 1;
        for (int i = 0; i < k; i++) p *= 3;
        return p;
    endfunction

    // wraps s into the balanced range; carry = (s - r) / P
    task automatic wrap(input longint s, output longint r, output longint cy);
        r = ((s % P) + P) % P;
        if (r > HALF) r -= P;
        cy = (s - r) / P;
    endtask

    task automatic model(output logic [WB-1:0] ew, output logic [1:0] ec, output logic ee);
        longint va = dec(a), vb = dec(b), vc = dec(c);
        longint r, cy, p;
        ec = 2'b00;
        ee = 1'b0;
        for (int i = 0; i < N; i++)
            if (a[2*i +: 2] == 2'b11 || b[2*i +: 2] == 2'b11 || c[2*i +: 2] == 2'b11) ee = 1'b1;
        if (pick == 2'b11) ee = 1'b1;
        case (op)
            3'd0: begin wrap(va + vb, r, cy); ew = enc(r); ec = enc1(cy); end
            3'd1: begin wrap(va - vb, r, cy); ew = enc(r); ec = enc1(cy); end
            3'd2: ew = enc(va < 0 ? -va : va);
            3'd3: ew = enc((va > vb) ? 1 : (va < vb) ? -1 : 0);
            3'd4: begin
                if (int'(shamt) >= N) ew = '0;
                else begin wrap(va * pow3(int'(shamt)), r, cy); ew = enc(r); end
            end
            3'd5: begin
                p = pow3(int'(shamt));
                if (int'(shamt) >= N) ew = '0;
                else if (va >= 0) ew = enc((va + (p - 1) / 2) / p);
                else ew = enc(-((-va + (p - 1) / 2) / p));
            end
            3'd6: ew = (pick == 2'b10) ? enc(va) : (pick == 2'b01) ? enc(vc) : enc(vb);
            default: ew = enc((sample < thr_lo) ? -1 : (sample > thr_hi) ? 1 : 0);
        endcase
    endtask

    task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic run_op();
        logic [WB-1:0] ew;
        logic [1:0] ec;
        logic ee;
        string t;
        model(ew, ec, ee);
        t = tag_of(op);
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "out_valid", 64'(out_valid), 64'd1);
        check(t, "result", 64'(result), 64'(ew));
        check((op <= 3'd1) ? t : "R13", "carry", 64'(carry), 64'(ec));
        check("R12", "err", 64'(err), 64'(ee));
    endtask

    task automatic set_op(input logic [2:0] o, input logic [WB-1:0] xa, input logic [WB-1:0] xb, input int k);
        op = o; a = xa; b = xb; shamt = SHW'(k);
    endtask

    initial begin
        logic [WB-1:0] hold_w;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R3 reset state
        check("R3", "out_valid", 64'(out_valid), 64'd0);
        check("R3", "result", 64'(result), 64'd0);
        check("R3", "carry", 64'(carry), 64'd0);
        check("R3", "err", 64'(err), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 overflow both ways
        set_op(3'd0, 16'h5555, 16'h5555, 0); run_op();
        check("R4", "max+max carry", 64'(carry), 64'h1);
        set_op(3'd0, 16'hAAAA, 16'hAAAA, 0); run_op();
        check("R4", "min+min carry", 64'(carry), 64'h2);
        // R5 self subtract and underflow
        set_op(3'd1, 16'h1659, 16'h1659, 0); run_op();
        set_op(3'd1, 16'hAAAA, 16'h5555, 0); run_op();
        // R6 most negative word
        set_op(3'd2, 16'hAAAA, 16'h0, 0); run_op();
        set_op(3'd2, 16'h0000, 16'h0, 0); run_op();
        // R7 equal and top-trit decided
        set_op(3'd3, 16'h1269, 16'h1269, 0); run_op();
        set_op(3'd3, 16'h4000, 16'h2AAA, 0); run_op();
        // R8 / R9 boundary shifts
        set_op(3'd4, 16'h5555, 16'h0, N); run_op();
        set_op(3'd4, 16'h0009, 16'h0, N - 1); run_op();
        set_op(3'd5, 16'h5555, 16'h0, N); run_op();
        set_op(3'd5, enc(5), 16'h0, 1); run_op();
        set_op(3'd5, enc(-5), 16'h0, 1); run_op();
        // R10 each pick value and illegal pick
        a = enc(7); b = enc(-3); c = enc(100); op = 3'd6;
        pick = 2'b10; run_op();
        pick = 2'b00; run_op();
        pick = 2'b01; run_op();
        pick = 2'b11; run_op();
        pick = 2'b00;
        // R11 threshold edges
        op = 3'd7; thr_lo = -16'sd10; thr_hi = 16'sd20;
        sample = -16'sd10; run_op();
        sample = 16'sd20; run_op();
        sample = -16'sd11; run_op();
        sample = 16'sd21; run_op();
        // R12 / R1 illegal code used as zero
        set_op(3'd0, enc(40), enc(13) | 16'h0C00, 0); run_op();
        set_op(3'd3, 16'h0003, 16'h0000, 0); run_op();

        // R2 hold after idle cycles
        hold_w = result;
        repeat (2) @(negedge clk);
        check("R2", "idle out_valid", 64'(out_valid), 64'd0);
        check("R2", "held result", 64'(result), 64'(hold_w));

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic signed [W-1:0] x0, x1;
            op = 3'($urandom % 8);
            a = rnd_word(); b = rnd_word(); c = rnd_word();
            if ($urandom % 16 == 0) a[2*($urandom % N) +: 2] = 2'b11;
            pick = 2'($urandom % 4);
            shamt = SHW'($urandom % (N + 2));
            x0 = W'($urandom); x1 = W'($urandom);
            thr_lo = (x0 < x1) ? x0 : x1;
            thr_hi = (x0 < x1) ? x1 : x0;
            sample = ($urandom % 4 == 0) ? thr_lo : W'($urandom);
            run_op();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule